// File: doc/BRIEF.md
# Sign-Aware Accumulator Barrel Shifter

This block is the scaling shifter of a fixed-point datapath. It takes a 40-bit operand, which is a 32-bit word with 8 guard bits above it, and moves it left or right by a signed amount. The result goes to an arithmetic unit or to the memory-write path. The amount comes from one of two places, selected by an input. The first is a 5-bit mode field. The second is a 6-bit shift-count register. A positive amount shifts left and a negative amount shifts right.

A mode input decides what enters at the top on a right shift: zeros or copies of bit 39. Alongside the shifter, an exponent detector counts the redundant sign bits of the operand and reports that count relative to the 32-bit word. Feeding that exponent back as the shift amount normalizes the value in one pass.

The datapath is combinational. A parameter can add one output register, and that register is on by default.

Top module: `acc_shifter`

## Requirements
- R1: A non-negative effective count k (0..31) shifts `operand` left by k. The k low bits of `result` are zero, and bits shifted past bit 39 are lost.
- R2: A negative effective count -k (k = 1..16) with `sign_ext` = 0 shifts right by k. The k top bits of `result` are zero.
- R3: A negative effective count -k with `sign_ext` = 1 shifts right by k. The k top bits of `result` equal bit 39 of `operand`.
- R4: `cnt_src` = 0 takes the count from `mode_cnt`, read as 5-bit two's complement (-16..15). `cnt_src` = 1 takes it from `treg_cnt`, read as 6-bit two's complement (-32..31).
- R5: A count below -16 is clamped to -16, which is a right shift by 16. The effective count always lies in -16..31.
- R6: `exponent` (6-bit two's complement) equals the number of bits below bit 39 that match bit 39, counted down from bit 38 up to the first mismatch, minus 8. It is 0 when `operand` is all zeros or all ones.
- R7: Re-applying an operand with `sign_ext` = 1 and `cnt_src` = 1, using its own `exponent` as `treg_cnt`, yields a `result` whose bit 31 differs from bit 30. This holds for any operand that is not all zeros or all ones.
- R8: With `REG_OUT` = 1, `result` and `exponent` appear one clock after the inputs. A synchronous active-high `rst` drives both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cnt_src | input | 1 | Count source: 0 mode field, 1 count register |
| mode_cnt | input | 5 | Signed shift amount from the mode field |
| treg_cnt | input | 6 | Signed shift amount from the count register |
| sign_ext | input | 1 | 1 fills vacated MSBs with bit 39 on right shifts |
| operand | input | 40 | Value to shift |
| result | output | 40 | Shifted value |
| exponent | output | 6 | Signed redundant-sign-bit count minus 8 |

## Verification
The assertions check four things on every clock: the effective count stays in its clamped range, a left shift leaves zeros in its vacated low bits, a right shift fills the top with zeros or with the sign as `sign_ext` demands, and an all-zero operand yields a zero exponent. Three properties are left to the bench's scenarios. The first is the exact shifted value across both count sources, compared against arithmetic and logical shift expressions. The second is the exact exponent of many operands. The third is the two-pass normalization property, since it links two separate operations.

// File: rtl/shf_pkg.sv
package shf_pkg;
    localparam int DATA_W    = 40;
    localparam int FIELD_W   = 5;
    localparam int TREG_W    = 6;
    localparam int MAX_LEFT  = 31;
    localparam int MAX_RIGHT = 16;
    localparam int GUARD_W   = 8;
    localparam int AMT_W     = 5;
    localparam int EXP_W     = 6;
    localparam int CNT_W     = 7;

    typedef struct packed {
        logic             go_right;
        logic [AMT_W-1:0] amt;
    } shift_ctl_t;

    // Redundant sign bits of a word minus the guard width; 0 for trivial words.
    function automatic logic signed [EXP_W-1:0] sign_exp(input logic [DATA_W-1:0] v);
        int  n;
        logic run;
        n   = 0;
        run = 1'b1;
        for (int i = DATA_W - 2; i >= 0; i--) begin
            if (run && (v[i] == v[DATA_W-1])) n++;
            else run = 1'b0;
        end
        if (n == DATA_W - 1) return '0;
        return EXP_W'(n - GUARD_W);
    endfunction
endpackage

// File: rtl/shf_count_sel.sv
module shf_count_sel
    import shf_pkg::*;
(
    input  logic                 cnt_src,
    input  logic [FIELD_W-1:0]   mode_cnt,
    input  logic [TREG_W-1:0]    treg_cnt,
    output logic signed [CNT_W-1:0] eff_cnt,
    output shift_ctl_t           ctl
);
    logic signed [CNT_W-1:0] raw;
    localparam logic signed [CNT_W-1:0] LO = -CNT_W'(MAX_RIGHT);
    localparam logic signed [CNT_W-1:0] HI = CNT_W'(MAX_LEFT);

    always_comb begin
        if (cnt_src) raw = CNT_W'($signed(treg_cnt));
        else         raw = CNT_W'($signed(mode_cnt));
        if (raw < LO)      eff_cnt = LO;
        else if (raw > HI) eff_cnt = HI;
        else               eff_cnt = raw;
        ctl.go_right = eff_cnt[CNT_W-1];
        if (eff_cnt[CNT_W-1]) ctl.amt = AMT_W'(-eff_cnt);
        else                  ctl.amt = AMT_W'(eff_cnt);
    end
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  shift_ctl_t        ctl,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] lst [0:AMT_W];
    logic [DATA_W-1:0] rst_ [0:AMT_W];
    logic              fill;

    assign fill    = sign_ext & din[DATA_W-1];
    assign lst[0]  = din;
    assign rst_[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int D = 1 << s;
        assign lst[s+1]  = ctl.amt[s] ? {lst[s][DATA_W-1-D:0], {D{1'b0}}} : lst[s];
        assign rst_[s+1] = ctl.amt[s] ? {{D{fill}}, rst_[s][DATA_W-1:D]} : rst_[s];
    end

    assign dout = ctl.go_right ? rst_[AMT_W] : lst[AMT_W];
endmodule

// File: rtl/shf_exp_detect.sv
module shf_exp_detect
    import shf_pkg::*;
(
    input  logic [DATA_W-1:0]       din,
    output logic signed [EXP_W-1:0] exp_val
);
    always_comb exp_val = sign_exp(din);
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
    import shf_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_src,
    input  logic [FIELD_W-1:0] mode_cnt,
    input  logic [TREG_W-1:0]  treg_cnt,
    input  logic               sign_ext,
    input  logic [DATA_W-1:0]  operand,
    output logic [DATA_W-1:0]  result,
    output logic [EXP_W-1:0]   exponent
);
    logic signed [CNT_W-1:0] eff_cnt;
    shift_ctl_t              ctl;
    logic [DATA_W-1:0]       shf_val;
    logic signed [EXP_W-1:0] exp_val;

    shf_count_sel u_sel (
        .cnt_src(cnt_src), .mode_cnt(mode_cnt), .treg_cnt(treg_cnt),
        .eff_cnt(eff_cnt), .ctl(ctl)
    );
    shf_core u_core (.din(operand), .ctl(ctl), .sign_ext(sign_ext), .dout(shf_val));
    shf_exp_detect u_exp (.din(operand), .exp_val(exp_val));

    if (REG_OUT) begin : g_reg
        logic [DATA_W-1:0] res_q;
        logic [EXP_W-1:0]  exp_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                exp_q <= '0;
            end else begin
                res_q <= shf_val;
                exp_q <= exp_val;
            end
        end
        assign result   = res_q;
        assign exponent = exp_q;
        p_reset_clear_r8: assert property (@(posedge clk) rst |=> (result == '0 && exponent == '0));
    end else begin : g_comb
        assign result   = shf_val;
        assign exponent = exp_val;
    end

    // R5: count always inside the supported range
    p_range_r5: assert property (@(posedge clk) disable iff (rst)
        (int'(eff_cnt) >= -MAX_RIGHT && int'(eff_cnt) <= MAX_LEFT));
    // R1: vacated low bits are zero on left shifts
    p_lsb_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (!ctl.go_right && ctl.amt != 0) |-> ((shf_val << (DATA_W - int'(ctl.amt))) == '0));
    // R2: zero fill on logical right shifts
    p_msb_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.go_right && !sign_ext) |-> ((shf_val >> (DATA_W - int'(ctl.amt))) == '0));
    // R3: sign fill on arithmetic right shifts
    p_msb_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.go_right && sign_ext) |-> (shf_val[DATA_W-1] == operand[DATA_W-1]));
    // R6: trivial operand gives zero exponent
    p_exp_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (operand == '0) |-> (exp_val == '0));
endmodule

// File: tb/sim_acc_shifter.sv
module sim_acc_shifter;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_src = 1'b0;
    logic [4:0] mode_cnt = '0;
    logic [5:0] treg_cnt = '0;
    logic sign_ext = 1'b0;
    logic [DW-1:0] operand = '0;
    logic [DW-1:0] result;
    logic [5:0] exponent;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_res_q[$];
    int            exp_exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_shifter u0 (
        .clk(clk), .rst(rst), .cnt_src(cnt_src), .mode_cnt(mode_cnt),
        .treg_cnt(treg_cnt), .sign_ext(sign_ext), .operand(operand),
        .result(result), .exponent(exponent)
    );

    function automatic logic [DW-1:0] ref_shift(logic [DW-1:0] v, int c, bit sx);
        logic signed [DW-1:0] s;
        s = v;
        if (c >= 0) return v << c;
        if (sx) return s >>> (-c);
        return v >> (-c);
    endfunction

    function automatic int ref_exp(logic [DW-1:0] v);
        int n = 0;
        if (v == '0 || v == '1) return 0;
        for (int i = DW - 2; i >= 0; i--) begin
            if (v[i] != v[DW-1]) break;
            n++;
        end
        return n - 8;
    endfunction

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive one vector, wait one registered cycle, compare result and exponent.
    task automatic apply(logic [DW-1:0] v, bit src, logic [4:0] m, logic [5:0] t, bit sx, string req);
        int c;
        c = src ? int'($signed(t)) : int'($signed(m));
        if (c < -16) c = -16;
        if (c > 31) c = 31;
        operand = v; cnt_src = src; mode_cnt = m; treg_cnt = t; sign_ext = sx;
        exp_res_q.push_back(ref_shift(v, c, sx));
        exp_exp_q.push_back(ref_exp(v));
        @(posedge clk); #1;
        begin
            logic [DW-1:0] er;
            int ee;
            er = exp_res_q.pop_front();
            ee = exp_exp_q.pop_front();
            check(result == er, req, result, er);
            check($signed(exponent) == ee, {req, " R6 exponent"},
                  DW'($signed(exponent)), DW'(ee));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(result == '0 && exponent == '0, "R8 reset", result, '0);
        rst = 1'b0;

        apply(40'h00_0000_0001, 1'b0, 5'd15, 6'd0, 1'b0, "R1 left 15");
        apply(40'hFF_FFFF_FFFF, 1'b1, 6'd0, 6'd31, 1'b0, "R1 left 31 via reg");
        apply(40'h12_3456_789A, 1'b0, 5'd0, 6'd0, 1'b1, "R1 zero shift");
        apply(40'h80_0000_0000, 1'b0, 5'h10, 6'd0, 1'b0, "R2 right 16 zero fill");
        apply(40'hF0_0000_0000, 1'b0, 5'h1F, 6'd0, 1'b0, "R2 right 1 zero fill");
        apply(40'h80_0000_0000, 1'b0, 5'h10, 6'd0, 1'b1, "R3 right 16 sign fill");
        apply(40'h7F_0000_0000, 1'b0, 5'h18, 6'd0, 1'b1, "R3 right 8 positive");
        apply(40'hA5_5A5A_5A5A, 1'b0, 5'h03, 6'h3D, 1'b1, "R4 mode field used");
        apply(40'hA5_5A5A_5A5A, 1'b1, 5'h03, 6'h3D, 1'b1, "R4 count reg used");
        apply(40'hC0_0000_0000, 1'b1, 5'd0, 6'h20, 1'b1, "R5 clamp -32");
        apply(40'hC0_0000_0000, 1'b1, 5'd0, 6'h2F, 1'b0, "R5 clamp -17");
        apply(40'h00_0000_0000, 1'b0, 5'd1, 6'd0, 1'b0, "R6 all zeros");
        apply(40'hFF_FFFF_FFFF, 1'b0, 5'd1, 6'd0, 1'b1, "R6 all ones");
        apply(40'h40_0000_0000, 1'b0, 5'd0, 6'd0, 1'b0, "R6 exp -8");

        // R7: normalize with the exponent reported by the first pass
        for (int k = 0; k < 40; k++) begin
            logic [DW-1:0] v;
            logic [5:0] e;
            v = {$urandom, $urandom} >> (k % 39);
            if (k % 3 == 0) v = ~v;
            if (v == '0 || v == '1) v = 40'h1;
            apply(v, 1'b0, 5'd0, 6'd0, 1'b1, "R7 first pass");
            e = exponent;
            apply(v, 1'b1, 5'd0, e, 1'b1, "R7 second pass");
            check(result[31] != result[30], "R7 normalized", result, {DW{1'bx}});
        end

        for (int k = 0; k < 300; k++) begin
            logic [DW-1:0] v;
            v = {$urandom, $urandom};
            if (k % 4 == 1) v = v >> ($urandom % 40);
            apply(v, 1'($urandom), 5'($urandom), 6'($urandom), 1'($urandom), "R1/R2/R3/R4 random");
        end

        rst = 1'b1;
        @(posedge clk); #1;
        check(result == '0 && exponent == '0, "R8 reset mid-run", result, '0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule